// File: doc/BRIEF.md
# Nibble-serial boot-memory bus target

This block is the target side of a narrow boot-memory bus. The bus carries one 4-bit nibble per clock plus an active-low frame line. The host opens a cycle by pulling the frame line low together with a start code. It then sends a target select nibble, which the block compares with a strap, followed by a 28-bit address. A write cycle also carries one data byte, split across two nibbles. The block turns the bus around, stretches the cycle with wait-state sync nibbles, and then returns the read byte or acknowledges the write. After that it gives the bus back.

On the inside the block presents a simple byte-wide port. The back end sees a held address, a one-cycle read request, read data that it must supply, and a one-cycle write strobe with its data byte. Two protection inputs hold back the write strobe for protected blocks. The host still sees a complete, normal handshake. Two resets can put the block into idle: an asynchronous hardware reset and a synchronous init input.

Top module: `nbt_target`

## Requirements
- R1: While hardware reset is low, and after its release until a cycle starts, `nib_oe`, `mem_rd` and `mem_wr` are all 0.
- R2: A cycle starts only at a rising edge where `frm_n` is 0 and `nib_i` is 4'hD (read) or 4'hE (write). Any other nibble under a low frame leaves the block idle and silent.
- R3: The nibble after the start is compared with `sel_strap`. On a mismatch the block stays tristated for the rest of the cycle and raises neither strobe.
- R4: The next 7 nibbles form the address, most significant nibble first. The address appears on `mem_addr` from the cycle after the last address nibble.
- R5: In a read, two turnaround cycles follow the address. The block drives 4'hF in the first of them, with `mem_rd` high for that one cycle, and releases the bus in the second.
- R6: The sync phase is WAIT_STATES cycles of 4'h5, then one cycle of 4'h0.
- R7: After the 4'h0 sync of a read, the block drives bits 3:0 and then bits 7:4 of the byte. The byte is taken from `mem_rdata` at the end of the 4'h0 sync cycle.
- R8: In a write, the two nibbles after the address are data bits 3:0 and then bits 7:4. Turnaround (4'hF, then released) and sync follow. `mem_wr` pulses during the 4'h0 sync cycle, with `mem_wdata` holding the byte.
- R9: Every completed cycle ends with one cycle of 4'hF, then one released cycle, then idle.
- R10: The top block is an address whose bits [19:16] are all ones. A write to the top block while `toplock_n` is 0, or to any other block while `wrprot_n` is 0, runs the same bus handshake but never raises `mem_wr`.
- R11: A low `frm_n` at any point aborts the current cycle. The following cycle is released, and a valid start in that same frame opens a new cycle.
- R12: `init_n` low at a rising edge returns the block to idle, so the next cycle is released and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| init_n | input | 1 | Init reset, active low, synchronous |
| frm_n | input | 1 | Frame line, active low |
| nib_i | input | 4 | Nibble received from the bus |
| nib_o | output | 4 | Nibble driven onto the bus |
| nib_oe | output | 1 | Output enable for the bus pads |
| sel_strap | input | 4 | Target select strap |
| wrprot_n | input | 1 | Write protect for all non-top blocks, active low |
| toplock_n | input | 1 | Write lock for the top block, active low |
| mem_addr | output | 28 | Captured address |
| mem_rd | output | 1 | Read request pulse |
| mem_rdata | input | 8 | Read data from the back end |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data byte |

## Verification
The bench goes after the nibble order. A design that swapped the halves of the read byte or shifted the address in the wrong direction would put wrong values on `nib_o` and `mem_addr`. It counts the exact sync length, because an off-by-one wait counter moves every later nibble by one cycle. It checks protected writes for each pairing of lock input and block, because a decode error would either block a legal write or let a locked one through while the bus looks normal. It aborts in the middle of the address phase and in the middle of sync, and applies init in the middle of sync. A block that ignored these would keep driving the bus into the next cycle.

// File: rtl/nbt_pkg.sv
`timescale 1ns/1ps
package nbt_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SEL, S_ADDR, S_WDAT, S_TAR, S_SYNC, S_RDAT, S_END
  } nbt_state_e;

  localparam logic [3:0] CODE_RD   = 4'hD;
  localparam logic [3:0] CODE_WR   = 4'hE;
  localparam logic [3:0] SYNC_WAIT = 4'h5;
  localparam logic [3:0] SYNC_RDY  = 4'h0;
  localparam logic [3:0] NIB_IDLE  = 4'hF;
endpackage

// File: rtl/nbt_rst_sync.sv
`timescale 1ns/1ps
module nbt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= 1'b0;
        else        sr_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/nbt_seq.sv
`timescale 1ns/1ps
module nbt_seq
  import nbt_pkg::*;
#(
  parameter int ADDR_NIB    = 7,
  parameter int WAIT_STATES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_n,
  input  logic       frm_n,
  input  logic [3:0] nib_i,
  input  logic [3:0] sel_strap,
  output nbt_state_e state_o,
  output logic       first_o,
  output logic       sync_rdy_o,
  output logic       is_wr_o
);
  localparam int MAXC  = (ADDR_NIB - 1 > WAIT_STATES) ? ADDR_NIB - 1 :
                         ((WAIT_STATES > 1) ? WAIT_STATES : 1);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIB - 1);
  localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(WAIT_STATES);
  localparam logic [CNT_W-1:0] PAIR_LAST = CNT_W'(1);

  nbt_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_d;
  logic             cnt_en, wr_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    unique case (state_q)
      S_IDLE: ;
      S_SEL: begin
        cnt_d   = '0;
        state_d = (nib_i == sel_strap) ? S_ADDR : S_IDLE;
      end
      S_ADDR: begin
        if (cnt_q == ADDR_LAST) begin
          cnt_d   = '0;
          state_d = wr_q ? S_WDAT : S_TAR;
        end else cnt_d = cnt_q + 1'b1;
      end
      S_WDAT: begin
        if (cnt_q == PAIR_LAST) begin
          cnt_d   = '0;
          state_d = S_TAR;
        end else cnt_d = cnt_q + 1'b1;
      end
      S_TAR: begin
        if (cnt_q == PAIR_LAST) begin
          cnt_d   = '0;
          state_d = S_SYNC;
        end else cnt_d = cnt_q + 1'b1;
      end
      S_SYNC: begin
        if (cnt_q == SYNC_LAST) begin
          cnt_d   = '0;
          state_d = wr_q ? S_END : S_RDAT;
        end else cnt_d = cnt_q + 1'b1;
      end
      S_RDAT: begin
        if (cnt_q == PAIR_LAST) begin
          cnt_d   = '0;
          state_d = S_END;
        end else cnt_d = cnt_q + 1'b1;
      end
      S_END: begin
        if (cnt_q == PAIR_LAST) begin
          cnt_d   = '0;
          state_d = S_IDLE;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: begin
        state_d = S_IDLE;
        cnt_d   = '0;
      end
    endcase
    // a low frame overrides everything: abort, then look for a start code
    if (!frm_n) begin
      cnt_d = '0;
      if (nib_i == CODE_RD || nib_i == CODE_WR) begin
        state_d = S_SEL;
        wr_d    = (nib_i == CODE_WR);
      end else begin
        state_d = S_IDLE;
      end
    end
    if (!init_n) begin
      state_d = S_IDLE;
      cnt_d   = '0;
      wr_d    = 1'b0;
    end
  end

  assign cnt_en = (cnt_d != cnt_q);
  assign wr_en  = (wr_d != wr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wr_q <= 1'b0;
    else if (wr_en) wr_q <= wr_d;
  end

  assign state_o    = state_q;
  assign first_o    = (cnt_q == '0);
  assign sync_rdy_o = (state_q == S_SYNC) && (cnt_q == SYNC_LAST);
  assign is_wr_o    = wr_q;
endmodule

// File: rtl/nbt_datapath.sv
`timescale 1ns/1ps
module nbt_datapath
  import nbt_pkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int BLK_LSB = 16,
  parameter int BLK_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  nbt_state_e        state,
  input  logic              first,
  input  logic              sync_rdy,
  input  logic              is_wr,
  input  logic [3:0]        nib_i,
  input  logic              wrprot_n,
  input  logic              toplock_n,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  output logic [7:0]        rbyte
);
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdat_q, rdat_q;
  logic              addr_en, wlo_en, whi_en, rlat_en;
  logic              top_blk, blocked;

  assign addr_en = (state == S_ADDR);
  assign wlo_en  = (state == S_WDAT) && first;
  assign whi_en  = (state == S_WDAT) && !first;
  assign rlat_en = sync_rdy && !is_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= {addr_q[ADDR_W-5:0], nib_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wdat_q[3:0] <= '0;
    else if (wlo_en) wdat_q[3:0] <= nib_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wdat_q[7:4] <= '0;
    else if (whi_en) wdat_q[7:4] <= nib_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdat_q <= '0;
    else if (rlat_en) rdat_q <= mem_rdata;
  end

  assign top_blk = &addr_q[BLK_LSB+BLK_W-1:BLK_LSB];
  assign blocked = top_blk ? !toplock_n : !wrprot_n;

  assign mem_addr  = addr_q;
  assign mem_wdata = wdat_q;
  assign rbyte     = rdat_q;
  assign mem_rd    = (state == S_TAR) && first && !is_wr;
  assign mem_wr    = sync_rdy && is_wr && !blocked;
endmodule

// File: rtl/nbt_drive.sv
`timescale 1ns/1ps
module nbt_drive
  import nbt_pkg::*;
(
  input  nbt_state_e state,
  input  logic       first,
  input  logic       sync_rdy,
  input  logic [7:0] rbyte,
  output logic [3:0] nib_o,
  output logic       nib_oe
);
  always_comb begin
    nib_o  = '0;
    nib_oe = 1'b0;
    unique case (state)
      S_TAR, S_END: begin
        nib_oe = first;
        nib_o  = first ? NIB_IDLE : 4'h0;
      end
      S_SYNC: begin
        nib_oe = 1'b1;
        nib_o  = sync_rdy ? SYNC_RDY : SYNC_WAIT;
      end
      S_RDAT: begin
        nib_oe = 1'b1;
        nib_o  = first ? rbyte[3:0] : rbyte[7:4];
      end
      default: begin
        nib_o  = '0;
        nib_oe = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/nbt_target.sv
`timescale 1ns/1ps
module nbt_target
  import nbt_pkg::*;
#(
  parameter int ADDR_NIB    = 7,
  parameter int WAIT_STATES = 2,
  parameter int BLK_LSB     = 16,
  parameter int BLK_W       = 4,
  parameter int RST_STAGES  = 2,
  localparam int ADDR_W     = 4 * ADDR_NIB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_n,
  input  logic              frm_n,
  input  logic [3:0]        nib_i,
  output logic [3:0]        nib_o,
  output logic              nib_oe,
  input  logic [3:0]        sel_strap,
  input  logic              wrprot_n,
  input  logic              toplock_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata
);
  logic       rst_sync_n;
  nbt_state_e state;
  logic       first, sync_rdy, is_wr;
  logic [7:0] rbyte;

  nbt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  nbt_seq #(.ADDR_NIB(ADDR_NIB), .WAIT_STATES(WAIT_STATES)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .init_n(init_n), .frm_n(frm_n),
    .nib_i(nib_i), .sel_strap(sel_strap), .state_o(state),
    .first_o(first), .sync_rdy_o(sync_rdy), .is_wr_o(is_wr)
  );

  nbt_datapath #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .BLK_W(BLK_W)) u_dp (
    .clk(clk), .rst_n(rst_sync_n), .state(state), .first(first),
    .sync_rdy(sync_rdy), .is_wr(is_wr), .nib_i(nib_i),
    .wrprot_n(wrprot_n), .toplock_n(toplock_n), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .rbyte(rbyte)
  );

  nbt_drive u_drv (
    .state(state), .first(first), .sync_rdy(sync_rdy), .rbyte(rbyte),
    .nib_o(nib_o), .nib_oe(nib_oe)
  );
endmodule

// File: rtl/nbt_target_chk.sv
`timescale 1ns/1ps
module nbt_target_chk #(
  parameter int BLK_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_n,
  input logic             frm_n,
  input logic [3:0]       nib_o,
  input logic             nib_oe,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic             wrprot_n,
  input logic             toplock_n,
  input logic [BLK_W-1:0] blk_field
);
  // R11
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_n |=> !nib_oe);

  // R12
  init_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |=> (!nib_oe && !mem_rd && !mem_wr));

  // R5
  rd_tar_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (nib_oe && nib_o == 4'hF));

  // R5
  rd_tar_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !nib_oe);

  // R6
  wait_then_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_oe && nib_o == 4'h5 && frm_n && init_n) |=> nib_oe);

  // R8
  wr_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (nib_oe && nib_o == 4'h0));

  // R8
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  // R10
  wr_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ((&blk_field) ? toplock_n : wrprot_n));
endmodule

bind nbt_target nbt_target_chk #(.BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_n(init_n), .frm_n(frm_n),
  .nib_o(nib_o), .nib_oe(nib_oe), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .wrprot_n(wrprot_n), .toplock_n(toplock_n),
  .blk_field(mem_addr[BLK_LSB+BLK_W-1:BLK_LSB])
);

// File: tb/nbt_target_tb.sv
`timescale 1ns/1ps
module nbt_target_tb;
  localparam int W = 2;
  localparam logic [3:0] STRAP = 4'h6;

  logic        clk = 1'b0;
  logic        rst_n, init_n, frm_n, wrprot_n, toplock_n;
  logic [3:0]  nib_i, nib_o, sel_strap;
  logic        nib_oe, mem_rd, mem_wr;
  logic [27:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;

  always #4 clk = ~clk;

  // behavioural back end: read byte is a function of the address
  assign mem_rdata = mem_addr[7:0] ^ 8'h3C;

  nbt_target #(.WAIT_STATES(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .frm_n(frm_n),
    .nib_i(nib_i), .nib_o(nib_o), .nib_oe(nib_oe), .sel_strap(sel_strap),
    .wrprot_n(wrprot_n), .toplock_n(toplock_n), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata)
  );

  task automatic step(input logic fr, input logic [3:0] nb, input logic ini,
                      input bit eoe, input logic [3:0] ev, input bit erd,
                      input bit ewr, input string tag);
    @(negedge clk);
    frm_n = fr; nib_i = nb; init_n = ini;
    #1;
    checks++;
    if (nib_oe !== eoe || (eoe && nib_o !== ev) || mem_rd !== erd || mem_wr !== ewr) begin
      fails++;
      $display("FAIL %s: oe=%b nib=%h rd=%b wr=%b expected oe=%b nib=%h rd=%b wr=%b",
               tag, nib_oe, nib_o, mem_rd, mem_wr, eoe, ev, erd, ewr);
    end
  endtask

  task automatic chk_val(input logic [35:0] act, input logic [35:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle; pre: start already sent; abort_at: cycle index that
  // carries an abort (frame low with acode, or init low when use_init)
  task automatic txn(input bit wr, input logic [3:0] idn, input logic [27:0] a,
                     input logic [7:0] wd, input bit pre, input int abort_at,
                     input logic [3:0] acode, input bit use_init);
    bit hit = (idn == STRAP);
    bit prot = (a[19:16] == 4'hF) ? !toplock_n : !wrprot_n;
    logic [7:0] rb = a[7:0] ^ 8'h3C;
    for (int k = 0; k < 16 + W; k++) begin
      logic fr = 1'b1; logic ini = 1'b1; logic [3:0] nb = 4'hF;
      bit eoe = 0; logic [3:0] ev = 4'h0; bit erd = 0; bit ewr = 0;
      string tag = "R9";
      if (k == 0) begin fr = 1'b0; nb = wr ? 4'hE : 4'hD; tag = "R2"; end
      else if (k == 1) begin nb = idn; tag = "R3"; end
      else if (k <= 8) begin nb = a[4*(8-k) +: 4]; tag = "R4"; end
      else if (!hit) tag = "R3";
      else if (!wr) begin
        if (k == 9) begin eoe = 1; ev = 4'hF; erd = 1; tag = "R5"; end
        else if (k == 10) tag = "R5";
        else if (k <= 10 + W) begin eoe = 1; ev = 4'h5; tag = "R6"; end
        else if (k == 11 + W) begin eoe = 1; ev = 4'h0; tag = "R6"; end
        else if (k == 12 + W) begin eoe = 1; ev = rb[3:0]; tag = "R7"; end
        else if (k == 13 + W) begin eoe = 1; ev = rb[7:4]; tag = "R7"; end
        else if (k == 14 + W) begin eoe = 1; ev = 4'hF; end
      end else begin
        if (k == 9) begin nb = wd[3:0]; tag = "R8"; end
        else if (k == 10) begin nb = wd[7:4]; tag = "R8"; end
        else if (k == 11) begin eoe = 1; ev = 4'hF; tag = "R8"; end
        else if (k == 12) tag = "R8";
        else if (k <= 12 + W) begin eoe = 1; ev = 4'h5; tag = "R6"; end
        else if (k == 13 + W) begin
          eoe = 1; ev = 4'h0; ewr = !prot; tag = prot ? "R10" : "R8";
        end
        else if (k == 14 + W) begin eoe = 1; ev = 4'hF; end
      end
      if (k == 0 && pre) continue;
      if (k == abort_at) begin
        if (use_init) ini = 1'b0;
        else begin fr = 1'b0; nb = acode; end
      end
      step(fr, nb, ini, eoe, ev, erd, ewr, tag);
      if (hit && !wr && k == 9) chk_val({8'h0, mem_addr}, {8'h0, a}, "R4 address");
      if (hit && wr && k == 13 + W)
        chk_val({mem_wdata, mem_addr}, {wd, a}, "R8 write byte/address");
      if (k == abort_at) return;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 4'hF, 1'b1, 0, 4'h0, 0, 0, tag);
  endtask

  initial begin
    rst_n = 1'b0; init_n = 1'b1; frm_n = 1'b1; nib_i = 4'hF;
    sel_strap = STRAP; wrprot_n = 1'b1; toplock_n = 1'b1;
    // R1: reset held, then released
    idle(3, "R1");
    @(negedge clk); rst_n = 1'b1;
    idle(4, "R1");
    // R2: frame low with invalid codes must not start
    step(1'b0, 4'h0, 1'b1, 0, 4'h0, 0, 0, "R2");
    step(1'b1, STRAP, 1'b1, 0, 4'h0, 0, 0, "R2");
    step(1'b0, 4'hF, 1'b1, 0, 4'h0, 0, 0, "R2");
    idle(20, "R2");
    // R4 R5 R6 R7 R9: plain reads
    txn(0, STRAP, 28'h1234567, 8'h00, 0, -1, 4'h0, 0);
    txn(0, STRAP, 28'hFEDCBA9, 8'h00, 0, -1, 4'h0, 0);
    idle(2, "R9");
    // R3: wrong select stays silent
    txn(0, 4'h3, 28'h0000055, 8'h00, 0, -1, 4'h0, 0);
    txn(1, 4'h7, 28'h0000055, 8'hAA, 0, -1, 4'h0, 0);
    // R8: writes
    txn(1, STRAP, 28'h00A1234, 8'h5A, 0, -1, 4'h0, 0);
    txn(1, STRAP, 28'h0FF0001, 8'hC3, 0, -1, 4'h0, 0);
    // R10: protection pairings
    wrprot_n = 1'b0;
    txn(1, STRAP, 28'h0031000, 8'h11, 0, -1, 4'h0, 0);
    txn(1, STRAP, 28'h00F2000, 8'h22, 0, -1, 4'h0, 0);
    wrprot_n = 1'b1; toplock_n = 1'b0;
    txn(1, STRAP, 28'h00F3000, 8'h33, 0, -1, 4'h0, 0);
    txn(1, STRAP, 28'h0054000, 8'h44, 0, -1, 4'h0, 0);
    toplock_n = 1'b1;
    // R11: abort in address phase with a write start, then the write
    txn(0, STRAP, 28'h0777777, 8'h00, 0, 5, 4'hE, 0);
    txn(1, STRAP, 28'h0123456, 8'h99, 1, -1, 4'h0, 0);
    // R11: abort in sync with a read start, then the read
    txn(0, STRAP, 28'h0888888, 8'h00, 0, 12, 4'hD, 0);
    txn(0, STRAP, 28'h0ABCDEF, 8'h00, 1, -1, 4'h0, 0);
    // R11: abort to idle with an invalid code
    txn(0, STRAP, 28'h0999999, 8'h00, 0, 11, 4'h0, 0);
    idle(3, "R11");
    // R12: init during sync
    txn(0, STRAP, 28'h0246802, 8'h00, 0, 12, 4'h0, 1);
    idle(3, "R12");
    txn(0, STRAP, 28'h0135790, 8'h00, 0, -1, 4'h0, 0);
    idle(2, "R9");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule